// File: doc/BRIEF.md
# Verified Hash-Tree Node Cache

This block is a small on-chip store of hash-tree nodes that sits between an untrusted host and a trusted integrity root for a block store. Nodes use heap numbering: the root is node 1, and node n has children 2n and 2n+1. Every line of the cache holds a node index, a 160-bit digest, a trust flag, and two bits that record whether the node's left and right children were confirmed through it. Line 0 is pinned to the root. Its digest is the trusted root register, and it is seeded from `root_init` at reset.

The host decides what to cache and when to check it. It sends commands that:
- place a node with a digest of its choosing into a named line;
- confirm both children of a trusted parent;
- drop a line;
- ask whether a leaf may be read;
- submit a new leaf digest for a write.

Child confirmation and write updates use an external hash engine through a request and response port. The engine's input is a left digest and a right digest, in that order.

A node is trusted only after the hash of its two children matches the digest of a trusted parent. A node index can live in only one line, so an old digest cannot be replayed next to a fresh one. A write is accepted only when the whole path to the root is trusted. The parents are then recomputed bottom-up, and the root is rewritten.

Top module: `hnode_cache`

## Requirements
- R1: After reset, line 0 holds node 1, trusted, with digest `root_init`, and `trusted_root` equals `root_init`. No other line is occupied and `cmd_ready` is 1. Opcodes are: 1 load, 2 verify, 3 evict, 4 read check, 5 write; 0, 6 and 7 are illegal. Response codes are: 0 ok, 1 miss, 2 mismatch, 3 duplicate, 4 illegal.
- R2: A load with a nonzero line and a nonzero node that is resident nowhere writes the node and digest into the named line, leaves it untrusted, and answers ok.
- R3: A load whose node index is already resident in any line answers duplicate and changes nothing.
- R4: An illegal opcode, a load or evict naming line 0, and a load or write of node 0 each answer illegal and change nothing.
- R5: A verify on parent line p holding node n issues one hash request with the digest of node 2n as left and of node 2n+1 as right. If the result equals p's digest, both child lines become trusted and the answer is ok.
- R6: A verify answers mismatch when the parent line is empty or untrusted, when either child is not resident, or when the hash differs. On a mismatch no trust flag changes.
- R7: A read check of node k answers ok with k's digest on `rsp_digest` when k is resident and trusted. Otherwise it answers miss, and `rsp_digest` is zero on every response other than an ok read check.
- R8: A write of leaf k answers miss and changes no digest unless, at every level from k up to the root, both the node and its sibling are resident and trusted.
- R9: An accepted write issues exactly one hash request per level below the root. At each level the running digest is placed left when the current node is even and right when it is odd. The new digests replace those of the path lines, and the final result replaces the root line and `trusted_root`.
- R10: An evict of an occupied line, or a load over it, removes its trust. An evict of an empty line answers miss.
- R11: `cmd_ready` is low while a verify or write is in progress, and every accepted command yields exactly one single-cycle `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_init | input | DW | Trusted root digest loaded at reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Command opcode |
| cmd_line | input | LW | Cache line named by the command |
| cmd_node | input | IW | Node index named by the command |
| cmd_digest | input | DW | Digest for load or write |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 3 | Response code |
| rsp_digest | output | DW | Leaf digest on a successful read check |
| hreq_valid | output | 1 | Hash request held until answered |
| hreq_left | output | DW | Left input digest |
| hreq_right | output | DW | Right input digest |
| hrsp_valid | input | 1 | Hash result present |
| hrsp_digest | input | DW | Hash result |
| trusted_root | output | DW | Current trusted root digest |

## Verification
The hardest state to reach is a successful write three levels deep. Before it, every node and sibling on the leaf's path must have been loaded and then confirmed parent-first, and this requires a consistent model tree on the bench side. The stimulus builds that tree, seeds the root with it, and confirms it top-down. Along the way it injects a corrupted node, checks that the failed confirmation left every flag untouched, and replaces the node before confirming it again. Only then does it issue the write and compare the recomputed root, the interior digest and the hash-request count. A later eviction of one sibling shows that the same write is then refused.

// File: rtl/hnode_cache.sv
module hnode_cache #(
  parameter int LINES = 16,
  parameter int DW = 160,
  parameter int IW = 21,
  localparam int LW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] root_init,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_line,
  input  logic [IW-1:0] cmd_node,
  input  logic [DW-1:0] cmd_digest,
  output logic          rsp_valid,
  output logic [2:0]    rsp_code,
  output logic [DW-1:0] rsp_digest,
  output logic          hreq_valid,
  output logic [DW-1:0] hreq_left,
  output logic [DW-1:0] hreq_right,
  input  logic          hrsp_valid,
  input  logic [DW-1:0] hrsp_digest,
  output logic [DW-1:0] trusted_root
);
  localparam logic [2:0] OP_LOAD = 3'd1, OP_VERIFY = 3'd2, OP_EVICT = 3'd3,
                         OP_READ = 3'd4, OP_WRITE = 3'd5;
  localparam logic [2:0] C_OK = 3'd0, C_MISS = 3'd1, C_MISM = 3'd2,
                         C_DUP = 3'd3, C_ILL = 3'd4;
  localparam logic [IW-1:0] ROOT = IW'(1);

  typedef enum logic [1:0] {S_IDLE, S_VWAIT, S_WCHK, S_WHASH} st_t;
  st_t st;

  logic [LINES-1:0] vld, ver, lc, rc;
  logic [IW-1:0]    node [LINES];
  logic [DW-1:0]    dig  [LINES];

  logic [IW-1:0] cur, leaf_q;
  logic [DW-1:0] acc;
  logic [LW-1:0] pl_q, vl_q, vr_q;

  logic [IW-1:0] ka, kb, kx, ky;
  logic          ha, hb, hx, hy;
  logic [LW-1:0] la, lb, lx, ly;

  assign cmd_ready    = (st == S_IDLE);
  assign trusted_root = dig[0];
  assign hreq_valid   = (st == S_VWAIT) || (st == S_WHASH && cur != ROOT);

  always_comb begin
    if (st == S_VWAIT) begin
      hreq_left  = dig[vl_q];
      hreq_right = dig[vr_q];
    end else if (!cur[0]) begin
      hreq_left  = acc;
      hreq_right = dig[lb];
    end else begin
      hreq_left  = dig[lb];
      hreq_right = acc;
    end
  end

  always_comb begin
    if (st == S_IDLE) begin
      ka = cmd_node;
      kb = node[cmd_line] >> 1;
      kx = {node[cmd_line][IW-2:0], 1'b0};
      ky = {node[cmd_line][IW-2:0], 1'b1};
    end else begin
      ka = cur;
      kb = cur ^ IW'(1);
      kx = cur;
      ky = cur;
    end
  end

  always_comb begin
    ha = 1'b0; hb = 1'b0; hx = 1'b0; hy = 1'b0;
    la = '0;   lb = '0;   lx = '0;   ly = '0;
    for (int i = 0; i < LINES; i++) begin
      if (vld[i] && node[i] == ka) begin ha = 1'b1; la = LW'(i); end
      if (vld[i] && node[i] == kb) begin hb = 1'b1; lb = LW'(i); end
      if (vld[i] && node[i] == kx) begin hx = 1'b1; lx = LW'(i); end
      if (vld[i] && node[i] == ky) begin hy = 1'b1; ly = LW'(i); end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      rsp_valid  <= 1'b0;
      rsp_code   <= C_OK;
      rsp_digest <= '0;
      cur        <= '0;
      leaf_q     <= '0;
      acc        <= '0;
      pl_q       <= '0;
      vl_q       <= '0;
      vr_q       <= '0;
      vld        <= LINES'(1);
      ver        <= LINES'(1);
      lc         <= '0;
      rc         <= '0;
      for (int i = 0; i < LINES; i++) begin
        node[i] <= (i == 0) ? ROOT : '0;
        dig[i]  <= (i == 0) ? root_init : '0;
      end
    end else begin
      rsp_valid  <= 1'b0;
      rsp_digest <= '0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          case (cmd_op)
            OP_LOAD: begin
              rsp_valid <= 1'b1;
              if (cmd_line == '0 || cmd_node == '0) rsp_code <= C_ILL;
              else if (ha) rsp_code <= C_DUP;
              else begin
                if (vld[cmd_line] && hb) begin
                  if (node[cmd_line][0]) rc[lb] <= 1'b0;
                  else lc[lb] <= 1'b0;
                end
                vld[cmd_line]  <= 1'b1;
                ver[cmd_line]  <= 1'b0;
                lc[cmd_line]   <= 1'b0;
                rc[cmd_line]   <= 1'b0;
                node[cmd_line] <= cmd_node;
                dig[cmd_line]  <= cmd_digest;
                rsp_code       <= C_OK;
              end
            end
            OP_EVICT: begin
              rsp_valid <= 1'b1;
              if (cmd_line == '0) rsp_code <= C_ILL;
              else if (!vld[cmd_line]) rsp_code <= C_MISS;
              else begin
                if (hb) begin
                  if (node[cmd_line][0]) rc[lb] <= 1'b0;
                  else lc[lb] <= 1'b0;
                end
                vld[cmd_line] <= 1'b0;
                ver[cmd_line] <= 1'b0;
                lc[cmd_line]  <= 1'b0;
                rc[cmd_line]  <= 1'b0;
                rsp_code      <= C_OK;
              end
            end
            OP_READ: begin
              rsp_valid <= 1'b1;
              if (ha && ver[la]) begin
                rsp_code   <= C_OK;
                rsp_digest <= dig[la];
              end else rsp_code <= C_MISS;
            end
            OP_VERIFY: begin
              if (vld[cmd_line] && ver[cmd_line] && !node[cmd_line][IW-1] && hx && hy) begin
                pl_q <= cmd_line;
                vl_q <= lx;
                vr_q <= ly;
                st   <= S_VWAIT;
              end else begin
                rsp_valid <= 1'b1;
                rsp_code  <= C_MISM;
              end
            end
            OP_WRITE: begin
              if (cmd_node == '0) begin
                rsp_valid <= 1'b1;
                rsp_code  <= C_ILL;
              end else begin
                cur    <= cmd_node;
                leaf_q <= cmd_node;
                acc    <= cmd_digest;
                st     <= S_WCHK;
              end
            end
            default: begin
              rsp_valid <= 1'b1;
              rsp_code  <= C_ILL;
            end
          endcase
        end
        S_VWAIT: if (hrsp_valid) begin
          st        <= S_IDLE;
          rsp_valid <= 1'b1;
          if (hrsp_digest == dig[pl_q]) begin
            ver[vl_q] <= 1'b1;
            ver[vr_q] <= 1'b1;
            lc[pl_q]  <= 1'b1;
            rc[pl_q]  <= 1'b1;
            rsp_code  <= C_OK;
          end else rsp_code <= C_MISM;
        end
        S_WCHK: begin
          if (cur == ROOT) begin
            cur <= leaf_q;
            st  <= S_WHASH;
          end else if (ha && ver[la] && hb && ver[lb]) begin
            cur <= cur >> 1;
          end else begin
            rsp_valid <= 1'b1;
            rsp_code  <= C_MISS;
            st        <= S_IDLE;
          end
        end
        S_WHASH: begin
          if (cur == ROOT) begin
            dig[0]    <= acc;
            rsp_valid <= 1'b1;
            rsp_code  <= C_OK;
            st        <= S_IDLE;
          end else if (hrsp_valid) begin
            dig[la] <= acc;
            acc     <= hrsp_digest;
            cur     <= cur >> 1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hnode_cache_chk.sv
module hnode_cache_chk #(
  parameter int LINES = 16,
  parameter int DW = 160,
  parameter int IW = 21,
  localparam int LW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic [LW-1:0]    cmd_line,
  input logic             rsp_valid,
  input logic [2:0]       rsp_code,
  input logic             hreq_valid,
  input logic [DW-1:0]    hreq_left,
  input logic [DW-1:0]    hreq_right,
  input logic             hrsp_valid,
  input logic [DW-1:0]    trusted_root,
  input logic [LINES-1:0] vld,
  input logic [LINES-1:0] ver,
  input logic [LINES-1:0] lc,
  input logic [LINES-1:0] rc,
  input logic [IW-1:0]    node [LINES]
);
  logic dup_seen, bad_child;

  always_comb begin
    dup_seen  = 1'b0;
    bad_child = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      logic lfound, rfound;
      lfound = 1'b0;
      rfound = 1'b0;
      for (int j = 0; j < LINES; j++) begin
        if (i != j && vld[i] && vld[j] && node[i] == node[j]) dup_seen = 1'b1;
        if (vld[j] && ver[j] && node[j] == {node[i][IW-2:0], 1'b0}) lfound = 1'b1;
        if (vld[j] && ver[j] && node[j] == {node[i][IW-2:0], 1'b1}) rfound = 1'b1;
      end
      if ((lc[i] && !lfound) || (rc[i] && !rfound)) bad_child = 1'b1;
      if ((lc[i] || rc[i]) && !ver[i]) bad_child = 1'b1;
    end
  end

  a_r1_root_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    vld[0] && ver[0] && node[0] == IW'(1));

  a_r3_unique_nodes: assert property (@(posedge clk) disable iff (!rst_n)
    !dup_seen);

  a_r10_child_bits: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_child);

  a_r2_load_untrusted: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0 && $past(cmd_valid && cmd_ready && cmd_op == 3'd1))
      |-> !ver[$past(cmd_line)]);

  a_r6_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd2) |-> $stable(ver));

  a_r9_root_on_write_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trusted_root) |-> (rsp_valid && rsp_code == 3'd0));

  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid |-> !cmd_ready);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_valid && !hrsp_valid) |=> (hreq_valid && $stable(hreq_left) && $stable(hreq_right)));
endmodule

bind hnode_cache hnode_cache_chk #(.LINES(LINES), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_line(cmd_line), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .hreq_valid(hreq_valid), .hreq_left(hreq_left), .hreq_right(hreq_right),
  .hrsp_valid(hrsp_valid), .trusted_root(trusted_root),
  .vld(vld), .ver(ver), .lc(lc), .rc(rc), .node(node)
);

// File: tb/sim_hnode_cache.sv
`timescale 1ns/1ps
module sim_hnode_cache;
  localparam int DW = 160, IW = 21, LW = 4;
  localparam logic [2:0] LOAD = 1, VERIFY = 2, EVICT = 3, READ = 4, WRITE = 5;
  localparam logic [2:0] OK = 0, MISS = 1, MISM = 2, DUP = 3, ILL = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [DW-1:0] root_init;
  logic cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_op = 0;
  logic [LW-1:0] cmd_line = 0;
  logic [IW-1:0] cmd_node = 0;
  logic [DW-1:0] cmd_digest = 0;
  logic rsp_valid;
  logic [2:0] rsp_code;
  logic [DW-1:0] rsp_digest;
  logic hreq_valid;
  logic [DW-1:0] hreq_left, hreq_right;
  logic hrsp_valid = 0;
  logic [DW-1:0] hrsp_digest = 0;
  logic [DW-1:0] trusted_root;

  hnode_cache u0 (.*);

  int checks = 0, errors = 0, hcnt = 0;
  logic [2:0]    q_code [$];
  logic [DW-1:0] q_dig  [$];
  string         q_tag  [$];
  logic ready_after;

  function automatic logic [DW-1:0] hmix(input logic [DW-1:0] l, input logic [DW-1:0] r);
    return {l[DW-8:0], l[DW-1:DW-7]} ^ r ^ {5{32'h9e3779b9}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    if (hreq_valid) begin
      repeat (3) @(negedge clk);
      hrsp_digest = hmix(hreq_left, hreq_right);
      hrsp_valid = 1;
      hcnt++;
      @(negedge clk);
      hrsp_valid = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_code.size() == 0) chk(0, "R11 unexpected response", {157'd0, rsp_code}, '0);
      else begin
        logic [2:0] ec;
        logic [DW-1:0] ed;
        string tg;
        ec = q_code.pop_front();
        ed = q_dig.pop_front();
        tg = q_tag.pop_front();
        chk(rsp_code == ec, {tg, " code"}, {157'd0, rsp_code}, {157'd0, ec});
        chk(rsp_digest == ed, {tg, " digest"}, rsp_digest, ed);
      end
    end
  end

  task automatic cmd(input logic [2:0] op, input int line, input int nd, input logic [DW-1:0] d,
                     input logic [2:0] ec, input logic [DW-1:0] ed, input string tag);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    q_code.push_back(ec);
    q_dig.push_back(ed);
    q_tag.push_back(tag);
    cmd_op = op; cmd_line = LW'(line); cmd_node = IW'(nd); cmd_digest = d;
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    ready_after = cmd_ready;
    while (q_code.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", '0, '0);
    finish_run();
  end

  logic [DW-1:0] t [16];
  logic [DW-1:0] bad, nl8, n4, n2, n1;
  int h0;

  initial begin
    for (int i = 8; i < 16; i++) t[i] = {5{32'(i * 32'h01010101 + 7)}};
    for (int i = 7; i >= 1; i--) t[i] = hmix(t[2*i], t[2*i+1]);
    root_init = t[1];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !rsp_valid, "R1 ready after reset", {159'd0, cmd_ready}, 1);
    chk(trusted_root == t[1], "R1 root after reset", trusted_root, t[1]);
    cmd(READ, 0, 1, '0, OK, t[1], "R1 root trusted");
    cmd(READ, 0, 8, '0, MISS, '0, "R7 leaf absent");
    cmd(EVICT, 5, 0, '0, MISS, '0, "R10 evict empty");

    cmd(LOAD, 1, 2, t[2], OK, '0, "R2 load n2");
    cmd(LOAD, 2, 3, t[3], OK, '0, "R2 load n3");
    cmd(READ, 0, 2, '0, MISS, '0, "R2 untrusted after load");
    cmd(LOAD, 3, 2, t[5], DUP, '0, "R3 dup n2");
    cmd(LOAD, 3, 1, t[5], DUP, '0, "R3 dup root");
    cmd(LOAD, 0, 9, t[9], ILL, '0, "R4 load line0");
    cmd(LOAD, 3, 0, t[9], ILL, '0, "R4 node0");
    cmd(EVICT, 0, 0, '0, ILL, '0, "R4 evict line0");
    cmd(3'd7, 1, 0, '0, ILL, '0, "R4 opcode7");
    cmd(3'd0, 1, 0, '0, ILL, '0, "R4 opcode0");
    cmd(WRITE, 0, 0, t[1], ILL, '0, "R4 write node0");
    cmd(READ, 0, 1, '0, OK, t[1], "R4 root intact");

    h0 = hcnt;
    cmd(VERIFY, 0, 0, '0, OK, '0, "R5 verify root");
    chk(ready_after == 0, "R11 busy in verify", {159'd0, ready_after}, 0);
    chk(hcnt - h0 == 1, "R5 one hash", DW'(hcnt - h0), 1);
    cmd(READ, 0, 2, '0, OK, t[2], "R5 n2 trusted");
    cmd(READ, 0, 3, '0, OK, t[3], "R5 n3 trusted");
    cmd(LOAD, 1, 2, t[2], DUP, '0, "R3 dup keeps line");
    cmd(READ, 0, 2, '0, OK, t[2], "R3 n2 still trusted");

    bad = t[4] ^ 160'h1;
    cmd(LOAD, 4, 4, bad, OK, '0, "R2 load bad n4");
    cmd(LOAD, 5, 5, t[5], OK, '0, "R2 load n5");
    cmd(VERIFY, 1, 0, '0, MISM, '0, "R6 hash differs");
    cmd(READ, 0, 4, '0, MISS, '0, "R6 n4 unchanged");
    cmd(READ, 0, 5, '0, MISS, '0, "R6 n5 unchanged");
    cmd(VERIFY, 2, 0, '0, MISM, '0, "R6 children absent");
    cmd(VERIFY, 6, 0, '0, MISM, '0, "R6 empty parent");
    cmd(VERIFY, 4, 0, '0, MISM, '0, "R6 untrusted parent");
    cmd(EVICT, 4, 0, '0, OK, '0, "R10 evict bad n4");
    cmd(LOAD, 4, 4, t[4], OK, '0, "R2 reload n4");
    cmd(VERIFY, 1, 0, '0, OK, '0, "R5 verify n2");
    cmd(READ, 0, 4, '0, OK, t[4], "R5 n4 trusted");

    cmd(LOAD, 6, 8, t[8], OK, '0, "R2 load n8");
    cmd(LOAD, 7, 9, t[9], OK, '0, "R2 load n9");
    cmd(WRITE, 0, 8, t[1], MISS, '0, "R8 path untrusted");
    chk(trusted_root == t[1], "R8 root unchanged", trusted_root, t[1]);
    cmd(VERIFY, 4, 0, '0, OK, '0, "R5 verify n4");
    cmd(READ, 0, 8, '0, OK, t[8], "R7 leaf read");

    nl8 = {5{32'hcafe0008}};
    n4 = hmix(nl8, t[9]);
    n2 = hmix(n4, t[5]);
    n1 = hmix(n2, t[3]);
    h0 = hcnt;
    cmd(WRITE, 0, 8, nl8, OK, '0, "R9 write n8");
    chk(hcnt - h0 == 3, "R9 hash per level", DW'(hcnt - h0), 3);
    chk(trusted_root == n1, "R9 new root", trusted_root, n1);
    cmd(READ, 0, 8, '0, OK, nl8, "R9 leaf updated");
    cmd(READ, 0, 4, '0, OK, n4, "R9 n4 updated");
    cmd(READ, 0, 2, '0, OK, n2, "R9 n2 updated");
    cmd(READ, 0, 1, '0, OK, n1, "R9 root line updated");

    h0 = hcnt;
    cmd(WRITE, 0, 10, nl8, MISS, '0, "R8 leaf absent");
    chk(hcnt == h0, "R8 no hash", DW'(hcnt - h0), 0);
    cmd(EVICT, 5, 0, '0, OK, '0, "R10 evict n5");
    cmd(READ, 0, 5, '0, MISS, '0, "R10 n5 gone");
    cmd(WRITE, 0, 8, t[8], MISS, '0, "R8 sibling absent");
    chk(trusted_root == n1, "R8 root kept", trusted_root, n1);
    cmd(READ, 0, 8, '0, OK, nl8, "R8 leaf kept");
    cmd(LOAD, 7, 12, t[12], OK, '0, "R10 reload over n9");
    cmd(READ, 0, 9, '0, MISS, '0, "R10 n9 replaced");
    cmd(READ, 0, 12, '0, MISS, '0, "R10 n12 untrusted");

    finish_run();
  end
endmodule